// File: doc/BRIEF.md
# Write Strobe Qualifier and Latch

This block sits between the asynchronous active-low bus strobes of a memory-style interface and a synchronous command state machine. It samples chip-enable, write-enable and output-enable, plus a low-supply inhibit flag, through a short synchroniser chain. It treats the overlap of chip-enable low and write-enable low as one combined write strobe. The address and data buses go through a delay pipe of the same depth, so each sampled strobe level lines up with the bus values present when it was taken.

When the combined strobe begins, the address is latched. While the strobe stays active, the data latch follows the bus, so it ends up holding the last value seen before the first strobe line rises. The strobe's width is counted in clock cycles. When the strobe ends, a single one-clock write pulse is issued with the latched address and data, but only if the width reached the minimum and no inhibit condition was seen. The block also produces the read output-enable for the data drivers.

A controller built from four named states does the qualifying. `S_IDLE` waits for a strobe. `S_COUNT` counts a strobe that has not yet reached the minimum width. `S_HELD` is a strobe that is wide enough and still active. `S_FIRE` is the single cycle in which the pulse is presented. The transitions are:
- start: from `S_IDLE` or `S_FIRE` into `S_COUNT`, or straight into `S_HELD` when the minimum is one cycle.
- reach-width: `S_COUNT` to `S_HELD`.
- glitch-drop: `S_COUNT` to `S_IDLE`.
- inhibit-drop: `S_HELD` to `S_IDLE`.
- release: `S_HELD` to `S_FIRE`.
- retire: `S_FIRE` to `S_IDLE`.

Top module: `wr_strobe_qual`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_pulse` and `rd_oe` are 0 and `wr_addr` and `wr_data` are 0, whatever the strobe inputs do.
- R2: A write strobe exists only while `ce_n` and `we_n` are both low. The address latched is the value of `addr_in` at the sample where the later of the two lines fell. Address changes before or after that sample are not captured.
- R3: The data latched is the value of `data_in` at the last sample where both strobes were still low. A data value that arrives on the same sample as the first rising strobe line is not captured.
- R4: A qualified write gives exactly one `wr_pulse`, one clock wide. It is visible on the third clock edge after the sample where the strobe ended (two synchroniser stages plus one output register).
- R5: A strobe that is low for fewer than `MIN_WIDTH` consecutive samples (default 3) gives no pulse. A strobe that is low for exactly `MIN_WIDTH` samples gives a pulse.
- R6: If `oe_n` is low on any sample during the strobe, the write is dropped.
- R7: If `low_supply` is high on any sample during the strobe, or on the sample where the strobe ends, the write is dropped.
- R8: `rd_oe` is 1 exactly when the samples taken three edges earlier showed `ce_n`=0, `oe_n`=0 and `we_n`=1. In particular it is 0 during a write.
- R9: `wr_addr` and `wr_data` change only on a cycle where `wr_pulse` is 1. Dropped strobes leave them at the last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| low_supply | input | 1 | Supply-low inhibit, active high |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Write data bus |
| wr_pulse | output | 1 | One-clock qualified write event |
| wr_addr | output | ADDR_W | Address latched for the last write |
| wr_data | output | DATA_W | Data latched for the last write |
| rd_oe | output | 1 | Read output enable for the data drivers |

## Verification
The assertions check the following on every cycle:
- Each write pulse lasts one clock.
- A pulse never follows a sample where the strobe was still active, or a sample with the supply low.
- `rd_oe` only follows a sampled read condition.
- The latched address and data move only together with a pulse.

The scenarios exercise the behaviour that depends on history across many cycles:
- the exact width threshold;
- which bus value is caught at the later falling edge and at the earlier rising edge;
- an output-enable inhibit lasting a single sample in the middle of a strobe;
- the pulse arriving on the expected cycle after release.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_HELD  = 2'd2,
        S_FIRE  = 2'd3
    } wsq_state_t;

    // bit positions inside the synchronised control vector
    localparam int CTL_CE = 0;
    localparam int CTL_WE = 1;
    localparam int CTL_OE = 2;
    localparam int CTL_LV = 3;
    localparam int CTL_W  = 4;

endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wsq_rdgate.sv
module wsq_rdgate (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s_n,
    input  logic oe_s_n,
    input  logic we_s_n,
    output logic rd_oe
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_oe <= 1'b0;
        else        rd_oe <= !ce_s_n && !oe_s_n && we_s_n;
    end

endmodule

// File: rtl/wsq_fsm.sv
module wsq_fsm
    import wsq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int MIN_WIDTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_act,
    input  logic              oe_low,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] data_d,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int            CW    = $clog2(MIN_WIDTH + 1);
    localparam logic [CW-1:0] CMAX  = CW'(MIN_WIDTH);
    localparam bit            SHORT = (MIN_WIDTH <= 1);

    wsq_state_t        st, nx;
    logic [CW-1:0]     cnt, cnt_nx;
    logic              inh, inh_nx;
    logic [ADDR_W-1:0] a_lat, a_nx;
    logic [DATA_W-1:0] d_lat, d_nx;

    // next-state and latch logic
    always_comb begin
        nx     = st;
        cnt_nx = cnt;
        inh_nx = inh;
        a_nx   = a_lat;
        d_nx   = d_lat;
        unique case (st)
            S_IDLE, S_FIRE: begin
                if (strobe_act) begin
                    // start: later falling edge captures the address
                    cnt_nx = CW'(1);
                    inh_nx = oe_low | supply_low;
                    a_nx   = addr_d;
                    d_nx   = data_d;
                    nx     = SHORT ? S_HELD : S_COUNT;
                end else begin
                    nx = S_IDLE;
                end
            end
            S_COUNT: begin
                if (!strobe_act) begin
                    nx = S_IDLE;                 // glitch-drop
                end else begin
                    cnt_nx = cnt + CW'(1);
                    inh_nx = inh | oe_low | supply_low;
                    d_nx   = data_d;
                    if (cnt_nx >= CMAX) nx = S_HELD;   // reach-width
                end
            end
            S_HELD: begin
                if (!strobe_act) begin
                    nx = (inh || supply_low) ? S_IDLE : S_FIRE;
                end else begin
                    inh_nx = inh | oe_low | supply_low;
                    d_nx   = data_d;
                end
            end
            default: nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            inh   <= 1'b0;
            a_lat <= '0;
            d_lat <= '0;
        end else begin
            st    <= nx;
            cnt   <= cnt_nx;
            inh   <= inh_nx;
            a_lat <= a_nx;
            d_lat <= d_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= (nx == S_FIRE);
            if (nx == S_FIRE) begin
                wr_addr <= a_lat;
                wr_data <= d_lat;
            end
        end
    end

endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual
    import wsq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int MIN_WIDTH   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              low_supply,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_oe
);

    localparam int           BUS_W    = ADDR_W + DATA_W;
    localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'(4'b0111);

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic [BUS_W-1:0] bus_raw, bus_s;
    logic             act;

    always_comb begin
        ctl_raw         = '0;
        ctl_raw[CTL_CE] = ce_n;
        ctl_raw[CTL_WE] = we_n;
        ctl_raw[CTL_OE] = oe_n;
        ctl_raw[CTL_LV] = low_supply;
    end

    assign bus_raw = {addr_in, data_in};

    wsq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    wsq_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    assign act = !ctl_s[CTL_CE] && !ctl_s[CTL_WE];

    wsq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_WIDTH(MIN_WIDTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_act (act),
        .oe_low     (!ctl_s[CTL_OE]),
        .supply_low (ctl_s[CTL_LV]),
        .addr_d     (bus_s[BUS_W-1:DATA_W]),
        .data_d     (bus_s[DATA_W-1:0]),
        .wr_pulse   (wr_pulse),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    wsq_rdgate u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_s_n (ctl_s[CTL_CE]),
        .oe_s_n (ctl_s[CTL_OE]),
        .we_s_n (ctl_s[CTL_WE]),
        .rd_oe  (rd_oe)
    );

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LAT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              low_supply,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_oe
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R4

    AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(ce_n | we_n, LAT)); // R2

    AST_PULSE_NO_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !$past(low_supply, LAT)); // R7

    AST_RDOE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> ($past(ce_n, LAT) == 1'b0 && $past(oe_n, LAT) == 1'b0 && $past(we_n, LAT) == 1'b1)); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wr_addr) || !$stable(wr_data)) |-> wr_pulse); // R9

endmodule

bind wr_strobe_qual wsq_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LAT    (SYNC_STAGES + 1)
) u_wsq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .low_supply (low_supply),
    .wr_pulse   (wr_pulse),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_oe      (rd_oe)
);

// File: tb/tb_wr_strobe_qual.sv
module tb_wr_strobe_qual;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, low_supply = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          wr_pulse, rd_oe;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0;
    int n_err = 0;
    logic [AW-1:0] last_a = '0;
    logic [DW-1:0] last_d = '0;

    always #2 clk = ~clk;

    wr_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .MIN_WIDTH(3), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .low_supply(low_supply), .addr_in(addr_in), .data_in(data_in),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .rd_oe(rd_oe)
    );

    typedef struct packed {
        logic [1:0]    lead;
        logic [3:0]    width;
        logic          oe;
        logic          lv;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd3, 1'b1, 1'b0, 16'h1234, 16'hABCD, 1'b1},  // R5 exact width
        '{2'd0, 4'd2, 1'b1, 1'b0, 16'h2222, 16'h3333, 1'b0},  // R5 short
        '{2'd0, 4'd1, 1'b1, 1'b0, 16'h4444, 16'h5555, 1'b0},  // R5 glitch
        '{2'd2, 4'd4, 1'b1, 1'b0, 16'h5555, 16'h00AA, 1'b1},  // R2 ce leads
        '{2'd0, 4'd5, 1'b0, 1'b0, 16'h6666, 16'h7777, 1'b0},  // R6 oe low
        '{2'd1, 4'd5, 1'b1, 1'b1, 16'h8888, 16'h9999, 1'b0},  // R7 low supply
        '{2'd0, 4'd8, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 1'b1},
        '{2'd0, 4'd6, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; low_supply = 1'b0;
    endtask

    // watch six samples after the strobe end; pulse expected at position pos
    task automatic watch(input bit exp, input int pos, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string req);
        int hits = 0;
        int at = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (wr_pulse) begin
                hits++;
                at = i;
                if (exp) begin
                    check(wr_addr == a, req, "addr", 32'(wr_addr), 32'(a));
                    check(wr_data == d, req, "data", 32'(wr_data), 32'(d));
                end
            end
        end
        check(hits == (exp ? 1 : 0), req, "pulse count", 32'(hits), exp ? 32'd1 : 32'd0);
        if (exp) begin
            check(at == pos, "R4", "pulse position", 32'(at), 32'(pos));
            last_a = a;
            last_d = d;
        end else begin
            check(wr_addr == last_a && wr_data == last_d, "R9", "latch held",
                  {wr_addr, wr_data}, {last_a, last_d});
        end
    endtask

    task automatic run_vec(input vec_t v);
        idle_bus();
        tick(2);
        if (v.lead != 0) begin
            ce_n = 1'b0;
            addr_in = ~v.a;
            tick(int'(v.lead));
        end
        ce_n = 1'b0; we_n = 1'b0;
        addr_in = v.a; data_in = v.d;
        oe_n = v.oe; low_supply = v.lv;
        tick(1);
        addr_in = ~v.a;               // R2: later change ignored
        tick(int'(v.width) - 1);
        idle_bus();
        data_in = ~v.d;               // R3: arrives with the rise
        watch(v.exp, 3, v.a, v.d, "R5/R2/R3 vector");
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: strobes active during reset give nothing
        ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        check(!wr_pulse && !rd_oe, "R1", "outputs in reset", {wr_pulse, rd_oe}, 0);
        check(wr_addr == 0 && wr_data == 0, "R1", "latches in reset", {wr_addr, wr_data}, 0);
        idle_bus();
        tick(1);
        rst_n = 1'b1;
        tick(2);
        check(!wr_pulse && !rd_oe, "R1", "outputs after reset", {wr_pulse, rd_oe}, 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R3: we rises first, later data change while ce still low not taken
        idle_bus(); tick(2);
        ce_n = 1'b0; we_n = 1'b0; addr_in = 16'hA5A5; data_in = 16'h1111;
        tick(4);
        data_in = 16'h2222;
        tick(1);
        we_n = 1'b1; data_in = 16'h3333;
        @(negedge clk);
        ce_n = 1'b1;
        watch(1'b1, 2, 16'hA5A5, 16'h2222, "R3");

        // R6: oe low for a single mid-strobe sample
        idle_bus(); tick(2);
        ce_n = 1'b0; we_n = 1'b0; addr_in = 16'h0F0F; data_in = 16'hF0F0;
        tick(2); oe_n = 1'b0; tick(1); oe_n = 1'b1; tick(3);
        idle_bus();
        watch(1'b0, 3, 0, 0, "R6");

        // R7: low supply raised only on the release sample
        idle_bus(); tick(2);
        ce_n = 1'b0; we_n = 1'b0; addr_in = 16'h1357; data_in = 16'h2468;
        tick(5);
        ce_n = 1'b1; we_n = 1'b1; low_supply = 1'b1;
        watch(1'b0, 3, 0, 0, "R7");
        low_supply = 1'b0;

        // R8: read enable latency and off during write
        idle_bus(); tick(3);
        ce_n = 1'b0; oe_n = 1'b0;
        tick(2);
        check(!rd_oe, "R8", "rd_oe before latency", 32'(rd_oe), 0);
        tick(1);
        check(rd_oe, "R8", "rd_oe after latency", 32'(rd_oe), 1);
        oe_n = 1'b1; we_n = 1'b0;
        tick(4);
        check(!rd_oe, "R8", "rd_oe during write", 32'(rd_oe), 0);
        idle_bus();
        tick(6);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule